// File: doc/BRIEF.md
# Two-Wire Bus Byte-Memory Slave

This block is the slave side of a two-wire serial bus (SCL clock, SDA data). It sits in front of a 256-entry byte store and a single write-protect register, both of which live outside the block and are reached through a one-clock write strobe and a registered read port. The block samples both bus lines with the system clock and finds START and STOP conditions. It takes in the address byte, compares it with three strap inputs, and gives an acknowledge when it is addressed. After that it accepts a byte address and write data, or it streams read data for as long as the master keeps acknowledging.

The address byte is decoded against two 4-bit prefixes. One prefix selects the byte store and the other selects the write-protect register. A `mem_sel` output tells the store which target the current transfer uses. While the store reports that an internal write cycle is running, the block keeps SDA released and accepts nothing. SDA is never driven high. The block only asserts an open-drain pull-down enable.

Top module: `i2c_mem_slave`

## Requirements
- R1: The block ignores the bus until it sees a START, which is SDA falling while SCL is high. A STOP, which is SDA rising while SCL is high, returns it to idle with SDA released, so a byte sent after a STOP and without a new START gets no acknowledge.
- R2: The first byte after START arrives MSB first. Bits 7..4 are the prefix, bits 3..1 must equal `dev_sel[2:0]`, and bit 0 is the direction (1 = read, 0 = write). Prefix 4'b1010 with matching select bits is acknowledged by SDA held low for the whole ninth SCL high phase.
- R3: Any other prefix, or a select mismatch, gets no acknowledge, and SDA stays released until the next START.
- R4: Prefix 4'b0110 addresses the write-protect register. Writes in such a transfer strobe `mem_we` with `mem_sel` = 1, and the byte store is untouched.
- R5: In write direction, the byte address and every data byte are acknowledged. Each data byte gives exactly one `mem_we` pulse, carrying the byte at the current address, and the address then steps by one.
- R6: In read direction, the slave shifts out 8 bits MSB first and releases SDA on the ninth clock. A master acknowledge (SDA low) starts the next byte. A master no-acknowledge leaves SDA released until STOP or START.
- R7: The internal address steps after every byte and wraps from 255 to 0.
- R8: While `busy_i` = 1, a START does not start a transfer and no byte is acknowledged, so SDA stays released and `mem_we` stays low.
- R9: A repeated START in the middle of any transfer restarts address-byte reception without a STOP. The byte address set earlier is kept for a following read.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: During reset `sda_oe` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 = pull SDA low |
| dev_sel | input | 3 | Strap value compared with address-byte bits 3..1 |
| busy_i | input | 1 | Store is in an internal write cycle |
| mem_addr | output | 8 | Current byte address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-clock write strobe |
| mem_sel | output | 1 | 0 = byte store, 1 = write-protect register |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_addr` |

## Verification
The bench builds the block with the default parameters: two synchroniser stages, an 8-bit address and the two 4-bit prefixes. With these values the full address space is small enough to reach the 255-to-0 wrap in a short sequential run. The three strap bits are tied to 3'b101, so single-bit select mismatches on either side of the strap value can be applied. The bus runs at eight system clocks per quarter SCL period. This leaves the synchroniser latency well inside the SCL low time, which makes the placement of SDA changes meaningful to check.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_BADDR,
    ST_WDATA,
    ST_RDATA
  } st_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start    = scl & scl_q & sda_q & ~sda;
  assign stop     = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          PRE_W   = 4,
  parameter int          SEL_W   = 3,
  parameter logic [PRE_W-1:0] PRE_MEM = 4'b1010,
  parameter logic [PRE_W-1:0] PRE_WP  = 4'b0110
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   start,
  input  logic                   stop,
  input  logic                   sda_s,
  input  logic [SEL_W-1:0]       dev_sel,
  input  logic                   busy,
  input  logic [PRE_W+SEL_W:0]   mem_rdata,
  output logic                   sda_oe,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [PRE_W+SEL_W:0]   mem_wdata,
  output logic                   mem_we,
  output logic                   mem_sel
);
  localparam int BW = PRE_W + SEL_W + 1;
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BW);

  st_e           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;
  logic [ADDR_W-1:0] addr;
  logic          rw, tgt, ack_ph, mack;
  logic          hit_mem, hit_wp, accept;

  assign hit_mem = (sh[BW-1 -: PRE_W] == PRE_MEM) && (sh[SEL_W:1] == dev_sel);
  assign hit_wp  = (sh[BW-1 -: PRE_W] == PRE_WP)  && (sh[SEL_W:1] == dev_sel);

  always_comb begin
    case (st)
      ST_DEV:             accept = (hit_mem || hit_wp) && !busy;
      ST_BADDR, ST_WDATA: accept = !busy;
      default:            accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;  sh <= '0;  addr <= '0;
      rw <= 1'b0;  tgt <= 1'b0;  ack_ph <= 1'b0;  mack <= 1'b0;
      sda_oe <= 1'b0;  mem_we <= 1'b0;  mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (mem_we) addr <= addr + 1'b1;
      if (start) begin
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
        cnt    <= '0;
        st     <= busy ? ST_IDLE : ST_DEV;
      end else if (stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        ack_ph <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_BADDR, ST_WDATA: begin
            if (scl_rise && !ack_ph && cnt != CNT_FULL) begin
              sh  <= {sh[BW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && !ack_ph && cnt == CNT_FULL) begin
              if (accept) begin
                sda_oe <= 1'b1;
                ack_ph <= 1'b1;
                if (st == ST_DEV) begin
                  rw  <= sh[0];
                  tgt <= hit_wp;
                end else if (st == ST_BADDR) begin
                  addr <= ADDR_W'(sh);
                end else begin
                  mem_we    <= 1'b1;
                  mem_wdata <= sh;
                end
              end else begin
                st <= ST_IDLE;
              end
            end else if (scl_fall && ack_ph) begin
              ack_ph <= 1'b0;
              cnt    <= '0;
              if (st == ST_DEV && rw) begin
                st     <= ST_RDATA;
                sh     <= mem_rdata;
                sda_oe <= ~mem_rdata[BW-1];
              end else begin
                sda_oe <= 1'b0;
                st     <= (st == ST_DEV) ? ST_BADDR : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (ack_ph) begin
              if (scl_rise) begin
                mack <= ~sda_s;
              end else if (scl_fall) begin
                ack_ph <= 1'b0;
                cnt    <= '0;
                if (mack) begin
                  sh     <= mem_rdata;
                  sda_oe <= ~mem_rdata[BW-1];
                end else begin
                  sda_oe <= 1'b0;
                  st     <= ST_IDLE;
                end
              end
            end else if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                ack_ph <= 1'b1;
                addr   <= addr + 1'b1;
              end else begin
                sh     <= {sh[BW-2:0], 1'b0};
                sda_oe <= ~sh[BW-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_addr = addr;
  assign mem_sel  = tgt;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 8,
  parameter int               PRE_W       = 4,
  parameter int               SEL_W       = 3,
  parameter logic [PRE_W-1:0] PRE_MEM     = 4'b1010,
  parameter logic [PRE_W-1:0] PRE_WP      = 4'b0110
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [SEL_W-1:0]     dev_sel,
  input  logic                 busy_i,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [PRE_W+SEL_W:0] mem_wdata,
  output logic                 mem_we,
  output logic                 mem_sel,
  input  logic [PRE_W+SEL_W:0] mem_rdata
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       rise_d, fall_d, start_d, stop_d;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cs_cond u_cond (
    .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s),
    .scl_rise(rise_d), .scl_fall(fall_d), .start(start_d), .stop(stop_d)
  );

  i2cs_ctrl #(
    .ADDR_W(ADDR_W), .PRE_W(PRE_W), .SEL_W(SEL_W),
    .PRE_MEM(PRE_MEM), .PRE_WP(PRE_WP)
  ) u_ctrl (
    .clk(clk), .rst(rst), .scl_rise(rise_d), .scl_fall(fall_d),
    .start(start_d), .stop(stop_d), .sda_s(sda_s), .dev_sel(dev_sel),
    .busy(busy_i), .mem_rdata(mem_rdata), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_sel(mem_sel)
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic mem_we,
  input logic busy,
  input logic scl_s,
  input logic stop_d
);
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(busy));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_d |=> !sda_oe);

  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sda_oe && !mem_we));
endmodule

bind i2c_mem_slave i2cs_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .mem_we(mem_we),
  .busy(busy_i), .scl_s(scl_s), .stop_d(stop_d)
);

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_oe, mem_we, mem_sel;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_bus;
  logic [7:0] arr [256];
  logic [7:0] wp_reg;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_mem_slave uut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(3'b101), .busy_i(busy), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) arr[i] <= 8'(i) ^ 8'h5A;
      wp_reg <= 8'h00;
    end else if (mem_we) begin
      if (mem_sel) wp_reg <= mem_wdata;
      else arr[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem_sel ? wp_reg : arr[mem_addr];
  end

  // {expected ack, address byte}; strap 3'b101
  localparam logic [8:0] VEC [0:7] = '{
    9'h1AA, 9'h0A8, 9'h0AE, 9'h16A, 9'h02A, 9'h0EA, 9'h05A, 9'h0AC
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q_wait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    if (!m_scl) begin
      q_wait(); m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
    end
    m_sda = 1'b0; q_wait(); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    q_wait(); m_sda = 1'b0; q_wait(); m_scl = 1'b1; q_wait(); m_sda = 1'b1; q_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      q_wait(); m_sda = b[i]; q_wait(); m_scl = 1'b1; q_wait(); q_wait(); m_scl = 1'b0;
    end
    q_wait(); m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
    ack = ~sda_bus;
    q_wait(); m_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q_wait(); m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
      b = {b[6:0], sda_bus};
      q_wait(); m_scl = 1'b0;
    end
    q_wait(); m_sda = ~mack; q_wait(); m_scl = 1'b1; q_wait(); q_wait(); m_scl = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    chk("R11 sda_oe in reset", sda_oe, 0);
    chk("R11 mem_we in reset", mem_we, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R3 R4: address-byte table
    for (int k = 0; k < 8; k++) begin
      bus_start();
      send_byte(VEC[k][7:0], a);
      chk($sformatf("R2/R3 addr byte %0h ack", VEC[k][7:0]), a, VEC[k][8]);
      if (a) begin send_byte(8'h80, a); end
      bus_stop();
    end

    // R1: no START, byte ignored
    m_scl = 1'b0;
    send_byte(8'hAA, a);
    chk("R1 byte without START", a, 0);
    m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();

    // R5: write three bytes at 0x10
    bus_start();
    send_byte(8'hAA, a); chk("R5 dev ack", a, 1);
    send_byte(8'h10, a); chk("R5 byte address ack", a, 1);
    send_byte(8'hC1, a); chk("R5 data0 ack", a, 1);
    send_byte(8'hC2, a); chk("R5 data1 ack", a, 1);
    send_byte(8'hC3, a); chk("R5 data2 ack", a, 1);
    bus_stop();
    chk("R5 mem[10]", arr[8'h10], 8'hC1);
    chk("R5 mem[11]", arr[8'h11], 8'hC2);
    chk("R5 mem[12]", arr[8'h12], 8'hC3);
    chk("R5 mem[13] untouched", arr[8'h13], 8'h13 ^ 8'h5A);

    // R6 R9: random read via repeated START
    bus_start();
    send_byte(8'hAA, a); send_byte(8'h10, a);
    bus_start();
    send_byte(8'hAB, a); chk("R9 read addr after repeated START", a, 1);
    recv_byte(d, 1'b1); chk("R6 read byte0", d, 8'hC1);
    recv_byte(d, 1'b1); chk("R6 read byte1", d, 8'hC2);
    recv_byte(d, 1'b0); chk("R6 read byte2", d, 8'hC3);
    q_wait(); q_wait();
    chk("R6 released after NACK", sda_bus, 1);
    bus_stop();

    // R7: wrap on write and read
    bus_start();
    send_byte(8'hAA, a); send_byte(8'hFE, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    bus_stop();
    chk("R7 write wrap mem[FF]", arr[8'hFF], 8'h22);
    chk("R7 write wrap mem[00]", arr[8'h00], 8'h33);
    bus_start();
    send_byte(8'hAA, a); send_byte(8'hFF, a);
    bus_start();
    send_byte(8'hAB, a);
    recv_byte(d, 1'b1); chk("R7 read FF", d, 8'h22);
    recv_byte(d, 1'b0); chk("R7 read wraps to 00", d, 8'h33);
    bus_stop();

    // R4: write-protect register target
    bus_start();
    send_byte(8'h6A, a); send_byte(8'h20, a);
    send_byte(8'h5C, a); chk("R4 wp data ack", a, 1);
    bus_stop();
    chk("R4 wp register", wp_reg, 8'h5C);
    chk("R4 store untouched", arr[8'h20], 8'h20 ^ 8'h5A);

    // R9: repeated START mid-write restarts addressing
    bus_start();
    send_byte(8'hAA, a); send_byte(8'h30, a); send_byte(8'h77, a);
    bus_start();
    send_byte(8'hAA, a); chk("R9 restart dev ack", a, 1);
    send_byte(8'h31, a); send_byte(8'h88, a);
    bus_stop();
    chk("R9 mem[30]", arr[8'h30], 8'h77);
    chk("R9 mem[31]", arr[8'h31], 8'h88);

    // R8: busy ignores commands
    busy = 1'b1;
    bus_start();
    send_byte(8'hAA, a); chk("R8 no ack while busy", a, 0);
    send_byte(8'h40, a); chk("R8 byte address ignored", a, 0);
    send_byte(8'h99, a);
    bus_stop();
    busy = 1'b0;
    chk("R8 store unchanged", arr[8'h40], 8'h40 ^ 8'h5A);

    done = 1;
    summary();
    $finish;
  end
endmodule